// File: doc/BRIEF.md
# Gated Synchronous Binary Clock Divider

The block takes one input clock and produces a chain of divided clocks. With the default of three stages, these run at one half, one quarter and one eighth of the input rate. Every stage is a toggle flop clocked by the input clock. All stages therefore change on the same rising input edge. When the divided count wraps, every output falls on one edge.

A single run input controls the chain. The run input is captured on the falling edge of the input clock, and that captured value qualifies the next rising edge. A change of the run input can therefore only take effect while the clock is low. Stopping or restarting never produces a shortened high or low phase on any output.

An asynchronous master reset clears every stage and the run capture flop. A system can use it to line up the dividers of several instances.

Top module: `syncDivChain`

## Requirements
- R1: Output bit k (k = 0, 1, 2 by default) toggles once every 2^k advancing rising edges. Read as a binary number with bit 0 as the LSB, the outputs count up by exactly one on each advancing rising edge.
- R2: Outputs change only on rising edges of the input clock. When the count wraps from all ones to zero, all outputs fall on the same edge.
- R3: A rising edge advances the count if and only if the run input was high at the preceding falling edge. Run pulses that do not cover a falling edge have no effect.
- R4: While the captured run value is low, the outputs keep their levels. When run returns high, counting resumes from the frozen value.
- R5: Outside reset, no output high or low phase is shorter than one input clock period, even when the run input toggles at random.
- R6: Asserting the master reset forces all outputs to zero at once, without waiting for a clock edge, and holds them there while it stays asserted.
- R7: If the master reset is released while the clock is high and run is high, the first rising edge after the release advances the count to 1.
- R8: If the master reset is released while the clock is low and run is high, the first rising edge after the release does not advance. The second rising edge advances the count to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| masterRst | input | 1 | Asynchronous reset, active high; clears all stages |
| runEn | input | 1 | Run input, captured on the falling clock edge |
| divOut | output | STAGES | Bit k is the input clock divided by 2^(k+1) |

## Verification
A long run with the run input held high gives toggle counts over 64 edges that tell the three division ratios apart. It also shows that the wrap edge is shared by all outputs. Run pulses placed either across a falling edge or entirely inside a high phase separate falling-edge capture from level sensing. Reset releases placed in the high phase and in the low phase show the one-edge difference that the cleared capture flop causes. A random phase toggles the run input and occasionally the master reset at offsets that avoid clock edges, and compares every cycle against a bench model. During that phase a monitor measures every output phase width and checks when each change occurs.

// File: rtl/syncDivChain_pkg.sv
package syncDivChain_pkg;
  // Strobes passed from the run-gating control into the divider datapath.
  typedef struct packed {
    logic advance;   // this rising edge advances the count
    logic armed;     // gating flop has seen a falling edge since reset
  } divStrobe_t;
endpackage

// File: rtl/syncDivChain_ctrl.sv
module syncDivChain_ctrl
  import syncDivChain_pkg::*;
(
  input  logic       clkIn,
  input  logic       masterRst,
  input  logic       runEn,
  output divStrobe_t strobe
);
  logic runCapt;
  logic armedQ;

  // Capture on the falling edge so that gating changes only while the clock is low.
  always_ff @(negedge clkIn or posedge masterRst) begin
    if (masterRst) begin
      runCapt <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      runCapt <= runEn;
      armedQ  <= 1'b1;
    end
  end

  always_comb begin
    strobe.advance = runCapt;
    strobe.armed   = armedQ;
  end

  // The count can only advance after a falling edge has been seen since reset.
  always @(posedge clkIn) begin
    if (!masterRst && !armedQ)
      AST_NO_ADVANCE_UNARMED: assert (!runCapt); // R8
  end
endmodule

// File: rtl/syncDivChain_dp.sv
module syncDivChain_dp
  import syncDivChain_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clkIn,
  input  logic              masterRst,
  input  divStrobe_t        strobe,
  output logic [STAGES-1:0] divOut
);
  localparam int CARRY_W = STAGES + 1;

  logic [STAGES-1:0]  stageQ;
  logic [CARRY_W-1:0] carry;

  assign carry[0] = strobe.advance;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      assign carry[k+1] = carry[k] & stageQ[k];
      always_ff @(posedge clkIn or posedge masterRst) begin
        if (masterRst)
          stageQ[k] <= 1'b0;
        else if (carry[k])
          stageQ[k] <= ~stageQ[k];
      end
    end
  endgenerate

  assign divOut = stageQ;

  always @(negedge clkIn) begin
    if (masterRst)
      AST_RESET_CLEARS: assert (divOut == '0); // R6
  end

  AST_FREEZE_WHEN_IDLE: assert property (@(posedge clkIn) disable iff (masterRst)
    !strobe.advance |=> $stable(divOut)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clkIn) disable iff (masterRst)
    strobe.advance |=> divOut == STAGES'($past(divOut) + 1'b1)); // R1

  AST_WRAP_ALL_FALL: assert property (@(posedge clkIn) disable iff (masterRst)
    (strobe.advance && (&divOut)) |=> divOut == '0); // R2
endmodule

// File: rtl/syncDivChain.sv
module syncDivChain
  import syncDivChain_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clkIn,
  input  logic              masterRst,
  input  logic              runEn,
  output logic [STAGES-1:0] divOut
);
  divStrobe_t strobe;

  syncDivChain_ctrl u_ctrl (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .runEn     (runEn),
    .strobe    (strobe)
  );

  syncDivChain_dp #(.STAGES(STAGES)) u_dp (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .strobe    (strobe),
    .divOut    (divOut)
  );
endmodule

// File: tb/syncDivChain_tb.sv
module syncDivChain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int STAGES = 3;

  logic clkIn = 1'b0;
  logic masterRst = 1'b0;
  logic runEn = 1'b0;
  logic [STAGES-1:0] divOut;

  int nChecks = 0;
  int nFails = 0;
  bit compareOn = 0;

  syncDivChain #(.STAGES(STAGES)) u_dut (
    .clkIn(clkIn), .masterRst(masterRst), .runEn(runEn), .divOut(divOut)
  );

  always #HALF clkIn = ~clkIn;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bench model, written from R3, R6, R7 and R8.
  logic modelRun;
  logic [STAGES-1:0] modelCnt;
  always @(negedge clkIn or posedge masterRst)
    if (masterRst) modelRun <= 1'b0; else modelRun <= runEn;
  always @(posedge clkIn or posedge masterRst)
    if (masterRst) modelCnt <= '0;
    else if (modelRun) modelCnt <= modelCnt + 1'b1;

  // Cycle-by-cycle comparison, sampled 3 time units after the rising edge.
  initial forever begin
    @(posedge clkIn); #3;
    if (compareOn) check(divOut == modelCnt, "R1/R3 count", divOut, modelCnt);
  end

  // Edge-timing and pulse-width monitor (R2, R5).
  time lastChg [STAGES];
  bit  lastOk  [STAGES];
  int  toggles [STAGES];
  logic [STAGES-1:0] prevOut = '0;
  always @(divOut) begin
    for (int k = 0; k < STAGES; k++) begin
      if (divOut[k] !== prevOut[k]) begin
        if (masterRst) lastOk[k] = 0;
        else begin
          toggles[k]++;
          check(clkIn === 1'b1 && ($time % CLK_PERIOD) == HALF, "R2 edge on rising clk",
                int'($time % CLK_PERIOD), HALF);
          if (lastOk[k])
            check(($time - lastChg[k]) >= CLK_PERIOD, "R5 min phase width",
                  int'($time - lastChg[k]), CLK_PERIOD);
          lastChg[k] = $time;
          lastOk[k] = 1;
        end
      end
    end
    prevOut = divOut;
  end

  task automatic atOffset(input int off);
    @(posedge clkIn); #off;
  endtask

  initial begin
    int t0 [STAGES];
    logic [STAGES-1:0] frozen;
    int offs [6] = '{1, 2, 4, 6, 7, 9};
    void'($urandom(32'h5eed1));
    for (int k = 0; k < STAGES; k++) begin lastOk[k] = 0; toggles[k] = 0; end
    #1 masterRst = 1'b1;
    #1 check(divOut == '0, "R6 reset state", divOut, 0);
    repeat (3) atOffset(2);

    // R7: release in the high phase
    runEn = 1'b1;
    masterRst = 1'b0;
    @(posedge clkIn); #3;
    check(divOut == 3'd1, "R7 release while high", divOut, 1);
    compareOn = 1;

    // R1 / R2: ratios over 64 advancing edges, including wraps
    for (int k = 0; k < STAGES; k++) t0[k] = toggles[k];
    repeat (64) @(posedge clkIn);
    #3;
    for (int k = 0; k < STAGES; k++)
      check(toggles[k] - t0[k] == (64 >> k), "R1 toggle ratio", toggles[k] - t0[k], 64 >> k);

    // R2: drive to all ones, then check all fall together
    while (divOut != '1) begin @(posedge clkIn); #3; end
    @(posedge clkIn); #1;
    check(divOut == '0, "R2 wrap all fall", divOut, 0);

    // R4: freeze and resume
    atOffset(2); runEn = 1'b0; frozen = divOut;
    repeat (5) begin @(posedge clkIn); #3;
      check(divOut == frozen, "R4 hold while idle", divOut, frozen); end
    atOffset(2); runEn = 1'b1;
    @(posedge clkIn); #3;
    check(divOut == STAGES'(frozen + 1'b1), "R4 resume from frozen", divOut, STAGES'(frozen + 1'b1));

    // R3: a pulse that covers a falling edge advances exactly once
    atOffset(2); runEn = 1'b0; frozen = divOut;
    atOffset(2); runEn = 1'b1;
    atOffset(2); runEn = 1'b0;
    repeat (3) @(posedge clkIn); #3;
    check(divOut == STAGES'(frozen + 1'b1), "R3 captured pulse", divOut, STAGES'(frozen + 1'b1));

    // R3: a pulse inside the high phase only has no effect
    frozen = divOut;
    atOffset(1); runEn = 1'b1;
    #2 runEn = 1'b0;
    repeat (3) @(posedge clkIn); #3;
    check(divOut == frozen, "R3 high-phase pulse ignored", divOut, frozen);

    // R6: asynchronous reset in the middle of a phase
    runEn = 1'b1;
    repeat (3) @(posedge clkIn);
    #2 masterRst = 1'b1;
    #1 check(divOut == '0, "R6 async clear", divOut, 0);

    // R8: release in the low phase
    atOffset(7); masterRst = 1'b0;
    @(posedge clkIn); #3;
    check(divOut == '0, "R8 first edge skipped", divOut, 0);
    @(posedge clkIn); #3;
    check(divOut == 3'd1, "R8 second edge advances", divOut, 1);

    // Random phase: run toggles and occasional resets (R3, R4, R5)
    for (int i = 0; i < 2000; i++) begin
      atOffset(offs[$urandom_range(0, 5)]);
      if ($urandom_range(0, 2) == 0) runEn = ~runEn;
      if ($urandom_range(0, 99) == 0) masterRst = 1'b1;
      else if (masterRst && $urandom_range(0, 1) == 0) masterRst = 1'b0;
    end
    masterRst = 1'b0;
    repeat (4) @(posedge clkIn); #3;
    check(nChecks > 2000, "R5 random coverage", nChecks, 2000);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule